// File: doc/BRIEF.md
# Vector Byte-Shift, Interleave and Lane-Add Unit

This block is one execution slot of a 128-bit vector datapath. Each cycle it can accept one operation, carrying a destination vector, a source vector, a 64-bit scalar operand, an 8-bit immediate and a 3-bit operation code. One clock later it presents a 128-bit vector result and a 64-bit scalar result, together with a valid flag.

The unit covers six operations:
- a logical right shift of the whole source vector, counted in whole bytes, with zeros entering at the top;
- two interleaves, one taking the upper 64-bit halves of both vectors and one taking the lower halves;
- a move from a scalar register into a vector;
- a move from a vector into a scalar register;
- a sixteen-lane byte add.

The register file, the decoder and the memory pipeline sit around the unit and are not part of it.

Top module: `vec_shuffle_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `vec_result` and `scalar_result` are all zero, whatever the inputs are.
- R2: A cycle with `in_valid` high produces its result and `out_valid` = 1 after the next rising clock edge. A cycle with `in_valid` low gives `out_valid` = 0 after that edge, and both result ports keep their previous values.
- R3: Op code 0 (byte shift) gives `vec_result` byte i = `src_vec` byte (i+imm) when i+imm < 16, and 0 otherwise. Byte i is bits 8i+7:8i.
- R4: For op code 0, any `imm` value from 16 to 255 gives an all-zero `vec_result`.
- R5: Op code 1 (high interleave) gives `vec_result` = {src_vec[127:64], dst_vec[127:64]}.
- R6: Op code 2 (low interleave) gives `vec_result` = {src_vec[63:0], dst_vec[63:0]}.
- R7: Op code 3 (scalar to vector) gives `vec_result` = {64'b0, scalar_in}.
- R8: Op code 4 (vector to scalar) gives `scalar_result` = src_vec[63:0] and `vec_result` = 0. Every other op code gives `scalar_result` = 0.
- R9: Op code 5 (lane add) gives `vec_result` byte i = (dst_vec byte i + src_vec byte i) mod 256 for each of the 16 lanes. No carry passes from one lane to the next.
- R10: Op codes 6 and 7 give zero on both result ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation code |
| dst_vec | input | 128 | Destination vector operand |
| src_vec | input | 128 | Source vector operand |
| scalar_in | input | 64 | Scalar operand for the scalar-to-vector move |
| imm | input | 8 | Byte shift count |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| vec_result | output | 128 | Registered vector result |
| scalar_result | output | 64 | Registered scalar result |

## Verification
The byte shift is driven with a source in which every byte holds a distinct value. This shows which source byte landed in each lane, so an off-by-one count or the wrong shift direction stands out. Shift counts of 0, 1, 7 and 15 are used, and 16, 200 and 255 confirm that large counts clear the result. The two interleaves and the two moves use operands whose halves all differ, so a swapped half or stale upper bits cannot go unnoticed. The lane add is given 0xFF+0x01 and 0x80+0x80 lanes, which separate wrapping within a lane from a carry leaking into the next lane. Back-to-back strobes and idle gaps with changing inputs separate correct one-cycle timing from a result that is late or not held.

// File: rtl/vsu_pkg.sv
package vsu_pkg;
  typedef enum logic [2:0] {
    OP_SHR_BYTES     = 3'd0,
    OP_UNPACK_HI     = 3'd1,
    OP_UNPACK_LO     = 3'd2,
    OP_SCALAR_TO_VEC = 3'd3,
    OP_VEC_TO_SCALAR = 3'd4,
    OP_ADD_BYTES     = 3'd5
  } vsu_op_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/vsu_byte_shifter.sv
module vsu_byte_shifter #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned AMT_W  = 8
) (
  input  logic [LANES*LANE_W-1:0] src,
  input  logic [AMT_W-1:0]        amt,
  output logic [LANES*LANE_W-1:0] res
);
  // Each output lane picks the source lane amt places above it; any count
  // that matches no candidate (including counts >= LANES) leaves zero.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lane;
    always_comb begin
      lane = '0;
      for (int k = 0; k < int'(LANES) - i; k++) begin
        if (amt == AMT_W'(k)) lane = src[(i+k)*LANE_W +: LANE_W];
      end
    end
    assign res[i*LANE_W +: LANE_W] = lane;
  end
endmodule

// File: rtl/vsu_lane_adder.sv
module vsu_lane_adder #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] a,
  input  logic [LANES*LANE_W-1:0] b,
  output logic [LANES*LANE_W-1:0] sum
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign sum[i*LANE_W +: LANE_W] = a[i*LANE_W +: LANE_W] + b[i*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/vec_shuffle_unit.sv
module vec_shuffle_unit #(
  parameter int unsigned VEC_W    = 128,
  parameter int unsigned SCALAR_W = 64,
  parameter int unsigned IMM_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          op_sel,
  input  logic [VEC_W-1:0]    dst_vec,
  input  logic [VEC_W-1:0]    src_vec,
  input  logic [SCALAR_W-1:0] scalar_in,
  input  logic [IMM_W-1:0]    imm,
  output logic                out_valid,
  output logic [VEC_W-1:0]    vec_result,
  output logic [SCALAR_W-1:0] scalar_result
);
  import vsu_pkg::*;

  localparam int unsigned LANES = VEC_W / LANE_W;
  localparam int unsigned HALF  = VEC_W / 2;

  logic [VEC_W-1:0]    shr_res;
  logic [VEC_W-1:0]    add_res;
  logic [VEC_W-1:0]    vec_nxt;
  logic [SCALAR_W-1:0] sc_nxt;
  logic [VEC_W-1:0]    vec_q;
  logic [SCALAR_W-1:0] sc_q;
  logic                vld_q;
  vsu_op_e             op;

  assign op = vsu_op_e'(op_sel);

  vsu_byte_shifter #(.LANES(LANES), .LANE_W(LANE_W), .AMT_W(IMM_W)) u_shr (
    .src(src_vec), .amt(imm), .res(shr_res)
  );

  vsu_lane_adder #(.LANES(LANES), .LANE_W(LANE_W)) u_add (
    .a(dst_vec), .b(src_vec), .sum(add_res)
  );

  // Next-state selection
  always_comb begin
    vec_nxt = '0;
    sc_nxt  = '0;
    case (op)
      OP_SHR_BYTES:     vec_nxt = shr_res;
      OP_UNPACK_HI:     vec_nxt = {src_vec[VEC_W-1:HALF], dst_vec[VEC_W-1:HALF]};
      OP_UNPACK_LO:     vec_nxt = {src_vec[HALF-1:0], dst_vec[HALF-1:0]};
      OP_SCALAR_TO_VEC: vec_nxt = {{(VEC_W-SCALAR_W){1'b0}}, scalar_in};
      OP_VEC_TO_SCALAR: sc_nxt  = src_vec[SCALAR_W-1:0];
      OP_ADD_BYTES:     vec_nxt = add_res;
      default: begin
        vec_nxt = '0;
        sc_nxt  = '0;
      end
    endcase
  end

  // Registers with explicit clock enable on the result datapath
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vec_q <= '0;
      sc_q  <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        vec_q <= vec_nxt;
        sc_q  <= sc_nxt;
      end
    end
  end

  assign out_valid     = vld_q;
  assign vec_result    = vec_q;
  assign scalar_result = sc_q;
endmodule

// File: rtl/vec_shuffle_checker.sv
module vec_shuffle_checker #(
  parameter int unsigned VEC_W    = 128,
  parameter int unsigned SCALAR_W = 64,
  parameter int unsigned IMM_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [2:0]          op_sel,
  input logic [VEC_W-1:0]    dst_vec,
  input logic [VEC_W-1:0]    src_vec,
  input logic [SCALAR_W-1:0] scalar_in,
  input logic [IMM_W-1:0]    imm,
  input logic                out_valid,
  input logic [VEC_W-1:0]    vec_result,
  input logic [SCALAR_W-1:0] scalar_result
);
  localparam int unsigned HALF = VEC_W / 2;

  always_comb begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (!out_valid && vec_result == '0 && scalar_result == '0);
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(vec_result) && $stable(scalar_result)));

  assert_big_shift_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd0 && imm > IMM_W'(15)) |=> vec_result == '0);

  assert_unpack_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd1) |=>
      vec_result == {$past(src_vec[VEC_W-1:HALF]), $past(dst_vec[VEC_W-1:HALF])});

  assert_unpack_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd2) |=>
      vec_result == {$past(src_vec[HALF-1:0]), $past(dst_vec[HALF-1:0])});

  assert_scalar_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd3) |=>
      (vec_result[VEC_W-1:SCALAR_W] == '0 && vec_result[SCALAR_W-1:0] == $past(scalar_in)));

  assert_scalar_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd4) |=>
      (scalar_result == $past(src_vec[SCALAR_W-1:0]) && vec_result == '0));

  assert_scalar_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel != 3'd4) |=> scalar_result == '0);

  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[2:1] == 2'b11) |=> (vec_result == '0 && scalar_result == '0));
endmodule

bind vec_shuffle_unit vec_shuffle_checker #(
  .VEC_W(VEC_W), .SCALAR_W(SCALAR_W), .IMM_W(IMM_W)
) u_chk (.*);

// File: tb/tb_vec_shuffle_unit.sv
module tb_vec_shuffle_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   op_sel;
  logic [127:0] dst_vec, src_vec;
  logic [63:0]  scalar_in;
  logic [7:0]   imm;
  logic         out_valid;
  logic [127:0] vec_result;
  logic [63:0]  scalar_result;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_shuffle_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .dst_vec(dst_vec), .src_vec(src_vec), .scalar_in(scalar_in), .imm(imm),
    .out_valid(out_valid), .vec_result(vec_result), .scalar_result(scalar_result)
  );

  task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Independent model of the requirements
  task automatic model(input logic [2:0] op, input logic [127:0] d, s,
                       input logic [63:0] sc, input logic [7:0] im,
                       output logic [127:0] ev, output logic [63:0] es);
    ev = '0;
    es = '0;
    case (op)
      3'd0: for (int b = 0; b < 16; b++) begin
              int idx = b + int'(im);
              if (idx < 16) ev[b*8 +: 8] = s[idx*8 +: 8];
            end
      3'd1: ev = {s[127:64], d[127:64]};
      3'd2: ev = {s[63:0], d[63:0]};
      3'd3: ev = {64'd0, sc};
      3'd4: es = s[63:0];
      3'd5: for (int b = 0; b < 16; b++) ev[b*8 +: 8] = 8'(d[b*8 +: 8] + s[b*8 +: 8]);
      default: ;
    endcase
  endtask

  task automatic run_op(string req, logic [2:0] op, logic [127:0] d, s,
                        logic [63:0] sc, logic [7:0] im);
    logic [127:0] ev;
    logic [63:0]  es;
    model(op, d, s, sc, im, ev, es);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; dst_vec = d; src_vec = s; scalar_in = sc; imm = im;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 out_valid", {127'd0, out_valid}, 128'd1);
    chk({req, " vec"}, vec_result, ev);
    chk({req, " scalar"}, {64'd0, scalar_result}, {64'd0, es});
  endtask

  localparam logic [127:0] SEQ = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;
  localparam logic [127:0] ALT = 128'h0123456789ABCDEFFEDCBA9876543210;

  task automatic test_reset();
    rst_n = 1'b0;
    in_valid = 1'b1; op_sel = 3'd2; dst_vec = SEQ; src_vec = ALT;
    scalar_in = 64'hDEAD; imm = 8'd0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {127'd0, out_valid}, 128'd0);
    chk("R1 vec", vec_result, 128'd0);
    chk("R1 scalar", {64'd0, scalar_result}, 128'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_shift();
    run_op("R3 imm0", 3'd0, ALT, SEQ, 64'd0, 8'd0);
    run_op("R3 imm1", 3'd0, ALT, SEQ, 64'd0, 8'd1);
    run_op("R3 imm7", 3'd0, ALT, SEQ, 64'd0, 8'd7);
    run_op("R3 imm15", 3'd0, ALT, SEQ, 64'd0, 8'd15);
    run_op("R4 imm16", 3'd0, ALT, SEQ, 64'd0, 8'd16);
    run_op("R4 imm200", 3'd0, ALT, SEQ, 64'd0, 8'd200);
    run_op("R4 imm255", 3'd0, ALT, SEQ, 64'd0, 8'd255);
  endtask

  task automatic test_unpack();
    run_op("R5 hi", 3'd1, SEQ, ALT, 64'd0, 8'd3);
    run_op("R6 lo", 3'd2, SEQ, ALT, 64'd0, 8'd3);
    chk("R6 literal", vec_result, 128'hFEDCBA98765432107869_5A4B3C2D1E0F);
  endtask

  task automatic test_moves();
    run_op("R7 s2v", 3'd3, SEQ, ALT, 64'hA5A5_1234_5678_9ABC, 8'd0);
    run_op("R8 v2s", 3'd4, SEQ, ALT, 64'h1111, 8'd0);
    chk("R8 literal", {64'd0, scalar_result}, {64'd0, 64'hFEDCBA9876543210});
  endtask

  task automatic test_add();
    run_op("R9 wrap", 3'd5, {16{8'hFF}}, {16{8'h01}}, 64'd0, 8'd0);
    chk("R9 literal", vec_result, 128'd0);
    run_op("R9 half", 3'd5, {8{16'h8001}}, {8{16'h8040}}, 64'd0, 8'd0);
    run_op("R9 mixed", 3'd5, SEQ, ALT, 64'd0, 8'd0);
  endtask

  task automatic test_unused();
    run_op("R10 op6", 3'd6, SEQ, ALT, 64'hFFFF, 8'd1);
    run_op("R10 op7", 3'd7, SEQ, ALT, 64'hFFFF, 8'd1);
  endtask

  task automatic test_hold_and_b2b();
    logic [127:0] ea, eb;
    logic [63:0]  sa, sb;
    run_op("R2 setup", 3'd2, SEQ, ALT, 64'd0, 8'd0);
    model(3'd2, SEQ, ALT, 64'd0, 8'd0, ea, sa);
    op_sel = 3'd1; dst_vec = ALT; src_vec = SEQ; scalar_in = 64'h77;
    repeat (3) @(negedge clk);
    chk("R2 idle valid", {127'd0, out_valid}, 128'd0);
    chk("R2 idle hold", vec_result, ea);
    model(3'd5, SEQ, ALT, 64'd0, 8'd0, ea, sa);
    model(3'd4, SEQ, ALT, 64'd0, 8'd0, eb, sb);
    in_valid = 1'b1; op_sel = 3'd5; dst_vec = SEQ; src_vec = ALT;
    @(negedge clk);
    op_sel = 3'd4;
    chk("R2 b2b first", vec_result, ea);
    chk("R2 b2b valid", {127'd0, out_valid}, 128'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 b2b second", {64'd0, scalar_result}, {64'd0, sb});
    chk("R2 b2b second vec", vec_result, eb);
    @(negedge clk);
    chk("R2 drop valid", {127'd0, out_valid}, 128'd0);
  endtask

  initial begin
    test_reset();
    test_shift();
    test_unpack();
    test_moves();
    test_add();
    test_unused();
    test_hold_and_b2b();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule